// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative store of page translations that sits in front of a page walker. A requester hands it a virtual address together with the address-space identifier (ASID) of the running process. The block divides the address into a page number and an in-page offset. It answers with a hit and the physical address, or with a miss. Entries carry an ASID tag, so the mappings of several processes can coexist and a context switch does not have to empty the table. A global flush is still provided for the cases where software wants a clean table.

Requests enter through a valid/ready stage and answers leave through a valid/ready stage. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Its answer shows up with `rsp_valid` on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the answer stays pending and `req_ready` stays low, so no new request is taken. The hit and address outputs are computed from the table as it stands in each cycle. A fill or flush that lands during a stall is therefore reflected in the pending answer.

Fills (page number, ASID, frame number) and the flush are plain single-cycle strobes driven by the walker or the control logic. The page size is a parameter. Its offset width is log2 of the page size and need not be a multiple of four bits.

Top module: `xlat_cache`

## Requirements
- R1: The offset width is OFF_W = log2(PAGE_BYTES), for example 13 bits for an 8 KiB page. The offset is the address ANDed with OFF_W low ones, and the page number is the address shifted right by OFF_W.
- R2: On a hit, `rsp_pa` equals the stored frame number shifted left by OFF_W, ORed with the unchanged offset.
- R3: A lookup hits only when a valid entry matches both the page number and the ASID of the request. A page-number match under another ASID, or no match at all, is a miss with `rsp_hit`=0 and `rsp_pa`=0.
- R4: Entries for the same page number under different ASIDs coexist, and each one returns its own frame.
- R5: A flush invalidates every entry, so all later lookups miss until new fills arrive.
- R6: After a fill, an access to that page and ASID hits. A request accepted in the same cycle as the fill already sees it.
- R7: A fill with no matching entry goes to the lowest-index invalid entry. When the table is full, it goes to the entry named by a round-robin pointer. The pointer starts at 0, advances by one only on such a replacement, and wraps after the last entry.
- R8: A fill whose page number and ASID match a valid entry overwrites that entry's frame, never creating a duplicate, and leaves the pointer unchanged.
- R9: When a flush and a fill occur in the same cycle, the flush wins and the fill is dropped.
- R10: A request is accepted when `req_valid` and `req_ready` are high, and `rsp_valid` rises in the next cycle. `req_ready` equals !`rsp_valid` OR `rsp_ready`. A pending answer holds its request until `rsp_ready` is high.
- R11: Reset clears every valid bit and `rsp_valid`, so the first lookups after reset miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can take a request |
| req_va | input | VA_W | Virtual address to translate |
| req_asid | input | ASID_W | ASID of the requester |
| rsp_valid | output | 1 | Answer valid |
| rsp_ready | input | 1 | Consumer takes the answer |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | PA_W | Physical address on a hit, zero on a miss |
| fill_en | input | 1 | Write one translation this cycle |
| fill_vpn | input | VA_W-OFF_W | Page number to install |
| fill_asid | input | ASID_W | ASID tag to install |
| fill_pfn | input | PA_W-OFF_W | Frame number to install |
| flush_en | input | 1 | Invalidate all entries |

## Verification
The bench uses an 8 KiB page so that the 13-bit offset straddles a hex digit. A split made on a nibble boundary would corrupt offset bit 12 and the low page-number bit, and the 0xABCD and 0xBFFF addresses expose that. It installs the same page number under two ASIDs and then rewrites one of them. A design that ignored the tag would return the wrong process's frame, and one that appended a duplicate would produce a double hit. The bench fills a full table and replaces twice to pin down the victim order. It also drives a fill together with a flush, and a fill together with a request, to fix the same-cycle ordering. A back-pressure stall checks that a held answer neither changes its request nor accepts a new one.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Mask of n low ones; n is never above 63 in this block.
  function automatic logic [63:0] low_ones(input int unsigned n);
    return (64'd1 << n) - 64'd1;
  endfunction
endpackage

// File: rtl/xlat_addr_split.sv
module xlat_addr_split #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic [VA_W-1:0]  va,
  output logic [VPN_W-1:0] vpn,
  output logic [OFF_W-1:0] off
);
  import xlat_pkg::*;
  localparam logic [VA_W-1:0] OFF_MASK = VA_W'(low_ones(OFF_W));
  logic [VA_W-1:0] shifted;
  logic [VA_W-1:0] masked;
  always_comb begin
    shifted = va >> OFF_W;
    masked  = va & OFF_MASK;
    vpn     = shifted[VPN_W-1:0];
    off     = masked[OFF_W-1:0];
  end
endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] fill_hit_vec,
  input  logic               commit,
  output logic [IDX_W-1:0]   slot
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] hit_idx;
  logic             free_any;
  logic             hit_any;

  always_comb begin
    free_idx = '0;
    hit_idx  = '0;
    free_any = 1'b0;
    hit_any  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
      if (fill_hit_vec[i]) begin
        hit_idx = IDX_W'(i);
        hit_any = 1'b1;
      end
    end
    if (hit_any)       slot = hit_idx;
    else if (free_any) slot = free_idx;
    else               slot = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (commit && !hit_any && !free_any)
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= IDX_W'(ENTRIES - 1));
  // R7
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (fill_hit_vec == '0) && (valid_vec != '1)) |-> !valid_vec[slot]);
  // R8
  victim_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (fill_hit_vec != '0)) |-> fill_hit_vec[slot]);
endmodule

// File: rtl/xlat_entry_table.sv
module xlat_entry_table #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  look_vpn,
  input  logic [ASID_W-1:0] look_asid,
  output logic              look_hit,
  output logic [PFN_W-1:0]  look_pfn,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              flush_en
);
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] look_match;
  logic [ENTRIES-1:0] fill_match;
  logic [PFN_W-1:0]   pfn_arr [ENTRIES];
  logic [IDX_W-1:0]   slot;
  logic               commit;

  assign commit = fill_en && !flush_en;

  xlat_victim_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
    .fill_hit_vec(fill_match), .commit(commit), .slot(slot)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              v_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PFN_W-1:0]  pfn_q;
    logic              wr;

    assign wr            = commit && (slot == IDX_W'(g));
    assign valid_vec[g]  = v_q;
    assign pfn_arr[g]    = pfn_q;
    assign look_match[g] = v_q && (vpn_q == look_vpn) && (asid_q == look_asid);
    assign fill_match[g] = v_q && (vpn_q == fill_vpn) && (asid_q == fill_asid);

    always_ff @(posedge clk) begin
      if (!rst_n)        v_q <= 1'b0;
      else if (flush_en) v_q <= 1'b0;
      else if (wr)       v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr) begin
        vpn_q  <= fill_vpn;
        asid_q <= fill_asid;
        pfn_q  <= fill_pfn;
      end
    end
  end

  always_comb begin
    look_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (look_match[i]) look_pfn = look_pfn | pfn_arr[i];
  end
  assign look_hit = |look_match;

  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));
  // R5
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> (valid_vec == '0));
  // R6
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> valid_vec[$past(slot)]);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int ENTRIES    = 8,
  parameter int ASID_W     = 8,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PFN_W = PA_W - OFF_W,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_pa,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              flush_en
);
  logic              stg_valid;
  logic [VA_W-1:0]   stg_va;
  logic [ASID_W-1:0] stg_asid;
  logic [VPN_W-1:0]  look_vpn;
  logic [OFF_W-1:0]  look_off;
  logic              look_hit;
  logic [PFN_W-1:0]  look_pfn;

  assign req_ready = !stg_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;
      stg_va    <= '0;
      stg_asid  <= '0;
    end else if (req_ready) begin
      stg_valid <= req_valid;
      if (req_valid) begin
        stg_va   <= req_va;
        stg_asid <= req_asid;
      end
    end
  end

  xlat_addr_split #(.VA_W(VA_W), .OFF_W(OFF_W)) u_split (
    .va(stg_va), .vpn(look_vpn), .off(look_off)
  );

  xlat_entry_table #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
    .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .look_vpn(look_vpn), .look_asid(stg_asid),
    .look_hit(look_hit), .look_pfn(look_pfn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .flush_en(flush_en)
  );

  assign rsp_valid = stg_valid;
  assign rsp_hit   = stg_valid && look_hit;
  assign rsp_pa    = rsp_hit ? {look_pfn, look_off} : '0;

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(stg_va) && $stable(stg_asid)));
  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_pa == '0));
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int VA_W = 32, PA_W = 32, PAGE_BYTES = 8192, ENTRIES = 4, ASID_W = 4;
  localparam int OFF_W = 13, VPN_W = 19, PFN_W = 19;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, rsp_valid, rsp_ready, rsp_hit;
  logic [VA_W-1:0] req_va;
  logic [ASID_W-1:0] req_asid, fill_asid;
  logic [PA_W-1:0] rsp_pa;
  logic fill_en, flush_en;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BYTES(PAGE_BYTES),
               .ENTRIES(ENTRIES), .ASID_W(ASID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_asid(req_asid), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .flush_en(flush_en)
  );

  // op: 0 fill (va field holds page number), 1 lookup, 2 flush
  localparam int NV = 18;
  localparam logic [93:0] VEC [NV] = '{
    {2'd0, 32'h00000005, 4'h1, 19'h00100, 1'b0, 32'h00000000, 4'd6},
    {2'd1, 32'h0000ABCD, 4'h1, 19'h00000, 1'b1, 32'h00200BCD, 4'd2},  // R1 R2
    {2'd1, 32'h0000ABCD, 4'h2, 19'h00000, 1'b0, 32'h00000000, 4'd3},  // R3
    {2'd0, 32'h00000005, 4'h2, 19'h00900, 1'b0, 32'h00000000, 4'd4},
    {2'd1, 32'h0000ABCD, 4'h2, 19'h00000, 1'b1, 32'h01200BCD, 4'd4},  // R4
    {2'd1, 32'h0000ABCD, 4'h1, 19'h00000, 1'b1, 32'h00200BCD, 4'd4},
    {2'd1, 32'h0000BFFF, 4'h1, 19'h00000, 1'b1, 32'h00201FFF, 4'd1},  // R1
    {2'd1, 32'h0000A000, 4'h1, 19'h00000, 1'b1, 32'h00200000, 4'd1},
    {2'd1, 32'h00001FFF, 4'h1, 19'h00000, 1'b0, 32'h00000000, 4'd3},
    {2'd0, 32'h00000005, 4'h1, 19'h00077, 1'b0, 32'h00000000, 4'd8},
    {2'd1, 32'h0000A123, 4'h1, 19'h00000, 1'b1, 32'h000EE123, 4'd8},  // R8
    {2'd1, 32'h0000ABCD, 4'h2, 19'h00000, 1'b1, 32'h01200BCD, 4'd8},
    {2'd2, 32'h00000000, 4'h0, 19'h00000, 1'b0, 32'h00000000, 4'd5},
    {2'd1, 32'h0000ABCD, 4'h1, 19'h00000, 1'b0, 32'h00000000, 4'd5},  // R5
    {2'd1, 32'h0000ABCD, 4'h2, 19'h00000, 1'b0, 32'h00000000, 4'd5},
    {2'd0, 32'h0007FFFF, 4'hF, 19'h7FFFF, 1'b0, 32'h00000000, 4'd2},
    {2'd1, 32'hFFFFFFFF, 4'hF, 19'h00000, 1'b1, 32'hFFFFFFFF, 4'd2},
    {2'd1, 32'hFFFFFFFF, 4'hE, 19'h00000, 1'b0, 32'h00000000, 4'd3}
  };

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                         input logic [PFN_W-1:0] p);
    fill_en = 1; fill_vpn = v; fill_asid = a; fill_pfn = p;
    @(posedge clk); @(negedge clk);
    fill_en = 0;
  endtask

  task automatic do_flush();
    flush_en = 1;
    @(posedge clk); @(negedge clk);
    flush_en = 0;
  endtask

  task automatic do_look(input logic [VA_W-1:0] va, input logic [ASID_W-1:0] a,
                         input logic eh, input logic [PA_W-1:0] epa, input string rq);
    req_valid = 1; req_va = va; req_asid = a;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check({rq, " valid"}, 64'(rsp_valid), 64'd1);
    check({rq, " hit"}, 64'(rsp_hit), 64'(eh));
    check({rq, " pa"}, 64'(rsp_pa), 64'(epa));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_va = '0; req_asid = '0; rsp_ready = 1;
    fill_en = 0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0; flush_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R11: reset state
    check("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R11 req_ready", 64'(req_ready), 64'd1);
    do_look(32'h0000ABCD, 4'h1, 1'b0, 32'h0, "R11 first lookup");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][93:92])
        2'd0: do_fill(VEC[i][78:60], VEC[i][59:56], VEC[i][55:37]);
        2'd2: do_flush();
        default: do_look(VEC[i][91:60], VEC[i][59:56], VEC[i][36], VEC[i][35:4],
                         $sformatf("R%0d row %0d", VEC[i][3:0], i));
      endcase
    end

    // R7: fills into empty table take slots 0..3, then round-robin from 0
    do_flush();
    do_fill(19'd1, 4'h3, 19'h11);
    do_fill(19'd2, 4'h3, 19'h12);
    do_fill(19'd3, 4'h3, 19'h13);
    do_fill(19'd4, 4'h3, 19'h14);
    do_look(32'h00002000, 4'h3, 1'b1, 32'h00022000, "R7 full slot0");
    do_look(32'h00008000, 4'h3, 1'b1, 32'h00028000, "R7 full slot3");
    do_fill(19'd6, 4'h3, 19'h16);
    do_look(32'h00002000, 4'h3, 1'b0, 32'h0, "R7 evict slot0");
    do_look(32'h00004000, 4'h3, 1'b1, 32'h00024000, "R7 keep slot1");
    do_look(32'h0000C000, 4'h3, 1'b1, 32'h0002C000, "R7 new entry");
    do_fill(19'd7, 4'h3, 19'h17);
    do_look(32'h00004000, 4'h3, 1'b0, 32'h0, "R7 evict slot1");
    do_look(32'h00006000, 4'h3, 1'b1, 32'h00026000, "R7 keep slot2");

    // R9: flush and fill together, flush wins
    flush_en = 1; fill_en = 1; fill_vpn = 19'd9; fill_asid = 4'h3; fill_pfn = 19'h19;
    @(posedge clk); @(negedge clk);
    flush_en = 0; fill_en = 0;
    do_look(32'h00012000, 4'h3, 1'b0, 32'h0, "R9 dropped fill");
    do_look(32'h00006000, 4'h3, 1'b0, 32'h0, "R9 flushed");

    // R6: fill and request in the same cycle
    fill_en = 1; fill_vpn = 19'd10; fill_asid = 4'h3; fill_pfn = 19'h1A;
    req_valid = 1; req_va = 32'h00014005; req_asid = 4'h3;
    @(posedge clk); @(negedge clk);
    fill_en = 0; req_valid = 0;
    check("R6 same-cycle hit", 64'(rsp_hit), 64'd1);
    check("R6 same-cycle pa", 64'(rsp_pa), 64'h00034005);

    // R10: back-pressure
    rsp_ready = 0;
    req_valid = 1; req_va = 32'h00014005; req_asid = 4'h3;
    @(posedge clk); @(negedge clk);
    check("R10 rsp_valid", 64'(rsp_valid), 64'd1);
    check("R10 req_ready low", 64'(req_ready), 64'd0);
    req_va = 32'h00000000;
    @(posedge clk); @(negedge clk);
    check("R10 held hit", 64'(rsp_hit), 64'd1);
    check("R10 held pa", 64'(rsp_pa), 64'h00034005);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check("R10 next valid", 64'(rsp_valid), 64'd1);
    check("R10 next miss", 64'(rsp_hit), 64'd0);
    @(posedge clk); @(negedge clk);
    check("R10 drained", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule